// File: doc/BRIEF.md
# General-Purpose I/O Pin Bank

This block controls one bank of up to 32 general-purpose pins from a small register bus. Software chooses a direction for each pin. It drives output levels through two write-only command words: one raises the pins whose write bits are 1, the other lowers them. A single pin can therefore change without reading and rewriting the whole output latch. Pad levels come back through a two-stage synchronizer in the bank clock domain. The input word shows the real pad level of every pin, including pins that the bank itself drives.

The bank has three pad vectors: incoming level, driven level and drive enable. A parameter sets how many low pins are populated, so the last bank of a larger array can be partial. Unpopulated bits read as zero, ignore writes and never drive. Reads are combinational from the current address. A write takes effect on the rising clock edge where the select and write strobes are both high.

Top module: `pio_bank`

## Requirements
- R1: After reset every populated pin is an input. The direction word reads with all populated bits at 1, the output latch reads 0, and `pad_oe` and `pad_out` are 0.
- R2: A write to byte offset 0x08 sets every populated latch bit whose write bit is 1. Latch bits written as 0 keep their value. `pad_out` follows the latch from the cycle after the write.
- R3: A write to byte offset 0x0C clears every latch bit whose write bit is 1. Latch bits written as 0 keep their value.
- R4: Byte offset 0x00 is the direction word. Bit n at 1 makes pin n an input and bit n at 0 makes it an output, so `pad_oe[n]` is the inverse of the populated direction bit. The word reads back as written, masked to the populated pins.
- R5: Byte offset 0x10 returns the pad inputs through two flip-flop stages. A level applied before rising edge k is still old just after edge k and shows just after edge k+1.
- R6: The input word reports the pad level, not the latch, even for pins whose drive is enabled.
- R7: Bits at or above `LIVE_PINS` read 0 in every register, ignore all writes, and are 0 on `pad_out` and `pad_oe`.
- R8: Offsets 0x04, 0x08 and 0x0C all read the output latch. Writes to 0x04, 0x10 and to unmapped offsets change nothing, and unmapped offsets read 0. The word index is `bus_addr[ADDR_W-1:2]`.
- R9: While `bus_sel` is low, or `bus_wr` is low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, 1 = write |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 32 | Pad input levels |
| pad_out | output | 32 | Pad drive levels (output latch) |
| pad_oe | output | 32 | Pad drive enables, 1 = drive |

## Verification
The bench builds the bank with `LIVE_PINS` = 20, so the twelve upper bits are unpopulated. Every walking-one set, clear and direction write therefore crosses the boundary between live and dead bits. It sweeps all 32 bit positions through the set and clear words and probes all eight word offsets. It also measures the input latency edge by edge while pad levels differ from the driven latch.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int BANK_W = 32;

    typedef enum logic [2:0] {
        SEL_DIR = 3'd0,
        SEL_OUT = 3'd1,
        SEL_SET = 3'd2,
        SEL_CLR = 3'd3,
        SEL_IN  = 3'd4
    } reg_sel_e;

    function automatic logic [BANK_W-1:0] live_mask(input int pins);
        logic [BANK_W-1:0] m;
        m = '0;
        for (int i = 0; i < BANK_W; i++) begin
            if (i < pins) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/pio_regfile.sv
module pio_regfile
    import pio_pkg::*;
#(
    parameter int LIVE_PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          wr_sel,
    input  logic [BANK_W-1:0] wr_data,
    output logic [BANK_W-1:0] dir_q,
    output logic [BANK_W-1:0] latch_q
);

    localparam logic [BANK_W-1:0] LIVE = live_mask(LIVE_PINS);

    typedef struct packed {
        logic [BANK_W-1:0] dir;
        logic [BANK_W-1:0] latch;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_sel)
                SEL_DIR: st_d.dir   = wr_data & LIVE;
                SEL_SET: st_d.latch = st_q.latch | (wr_data & LIVE);
                SEL_CLR: st_d.latch = st_q.latch & ~wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.dir   <= LIVE;
            st_q.latch <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dir_q   = st_q.dir;
    assign latch_q = st_q.latch;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (dir_q == LIVE && latch_q == '0));

    // R2
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_SET) |=>
            ((latch_q & $past(wr_data) & LIVE) == ($past(wr_data) & LIVE)) &&
            ((latch_q & ~$past(wr_data)) == ($past(latch_q) & ~$past(wr_data))));

    // R3
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CLR) |=>
            ((latch_q & $past(wr_data)) == '0) &&
            ((latch_q & ~$past(wr_data)) == ($past(latch_q) & ~$past(wr_data))));

    // R4
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_DIR) |=> dir_q == ($past(wr_data) & LIVE));

endmodule

// File: rtl/pio_insync.sv
module pio_insync
    import pio_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] pad_in,
    output logic [BANK_W-1:0] sync_out
);

    typedef struct packed {
        logic [STAGES-1:0][BANK_W-1:0] stage;
        logic [1:0]                    age;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stage[0] = pad_in;
        for (int s = 1; s < STAGES; s++) begin
            st_d.stage[s] = st_q.stage[s-1];
        end
        if (st_q.age != 2'd3) st_d.age = st_q.age + 2'd1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_out = st_q.stage[STAGES-1];

    generate
        if (STAGES == 2) begin : g_lat_chk
            // R5
            sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.age >= 2'd2) |-> sync_out == $past(pad_in, 2));
        end
    endgenerate

endmodule

// File: rtl/pio_rdmux.sv
module pio_rdmux
    import pio_pkg::*;
#(
    parameter int LIVE_PINS = 32
) (
    input  logic              hit,
    input  reg_sel_e          sel,
    input  logic [BANK_W-1:0] dir_q,
    input  logic [BANK_W-1:0] latch_q,
    input  logic [BANK_W-1:0] sync_in,
    output logic [BANK_W-1:0] rdata
);

    localparam logic [BANK_W-1:0] LIVE = live_mask(LIVE_PINS);

    always_comb begin
        rdata = '0;
        if (hit) begin
            case (sel)
                SEL_DIR:                   rdata = dir_q;
                SEL_OUT, SEL_SET, SEL_CLR: rdata = latch_q;
                SEL_IN:                    rdata = sync_in & LIVE;
                default:                   rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/pio_bank.sv
module pio_bank
    import pio_pkg::*;
#(
    parameter int LIVE_PINS   = 32,
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       pad_in,
    output logic [31:0]       pad_out,
    output logic [31:0]       pad_oe
);

    localparam int IDX_W = ADDR_W - 2;
    localparam logic [BANK_W-1:0] LIVE = live_mask(LIVE_PINS);

    logic [IDX_W-1:0]  word_idx;
    logic              hit;
    reg_sel_e          sel;
    logic              wr_en;
    logic [BANK_W-1:0] dir_q, latch_q, sync_q;

    assign word_idx = bus_addr[ADDR_W-1:2];
    assign hit      = (word_idx <= IDX_W'(4));
    assign sel      = reg_sel_e'(word_idx[2:0]);
    assign wr_en    = bus_sel && bus_wr && hit;

    pio_regfile #(.LIVE_PINS(LIVE_PINS)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (sel),
        .wr_data (bus_wdata),
        .dir_q   (dir_q),
        .latch_q (latch_q)
    );

    pio_insync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_in   (pad_in),
        .sync_out (sync_q)
    );

    pio_rdmux #(.LIVE_PINS(LIVE_PINS)) i_rd (
        .hit     (hit),
        .sel     (sel),
        .dir_q   (dir_q),
        .latch_q (latch_q),
        .sync_in (sync_q),
        .rdata   (bus_rdata)
    );

    assign pad_out = latch_q;
    assign pad_oe  = ~dir_q & LIVE;

    // R7
    dead_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rdata | pad_out | pad_oe) & ~LIVE) == '0);

    // R9
    no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr) |=> ($stable(pad_out) && $stable(pad_oe)));

endmodule

// File: tb/test_pio_bank.sv
module test_pio_bank;

    localparam int LIVE = 20;
    localparam logic [31:0] MASK = 32'h000F_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] exp_latch = '0;
    logic [31:0] exp_dir = MASK;

    always #10 clk = ~clk;

    pio_bank #(.LIVE_PINS(LIVE), .ADDR_W(5), .SYNC_STAGES(2)) i_pio_bank (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic s = 1'b1);
        @(negedge clk);
        bus_sel = s; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(5'h00, v); check("R1 dir", v, MASK);
        rd(5'h04, v); check("R1 latch", v, 32'h0);
        check("R1 pad_oe", pad_oe, 32'h0);
        check("R1 pad_out", pad_out, 32'h0);

        // R2 walking set over all 32 positions, R7 dead bits
        for (int i = 0; i < 32; i++) begin
            wr(5'h08, 32'h1 << i);
            exp_latch = exp_latch | ((32'h1 << i) & MASK);
            rd(5'h04, v); check("R2 set walk", v, exp_latch);
            check("R7 pad_out dead", pad_out, exp_latch);
        end

        // R3 walking clear of every other bit, then all
        for (int i = 0; i < 32; i += 2) begin
            wr(5'h0C, 32'h1 << i);
            exp_latch = exp_latch & ~(32'h1 << i);
            rd(5'h04, v); check("R3 clr walk", v, exp_latch);
        end
        wr(5'h0C, 32'hFFFF_FFFF); exp_latch = 0;
        rd(5'h04, v); check("R3 clr all", v, 32'h0);

        // R8 set and clear words read the latch
        wr(5'h08, 32'hA5A5_A5A5); exp_latch = 32'hA5A5_A5A5 & MASK;
        wr(5'h0C, 32'h0F0F_0F0F); exp_latch = exp_latch & ~32'h0F0F_0F0F;
        rd(5'h08, v); check("R8 set readback", v, exp_latch);
        rd(5'h0C, v); check("R8 clr readback", v, exp_latch);
        check("R2 pad_out", pad_out, exp_latch);

        // R4 direction patterns, R7 dead bits
        for (int k = 0; k < 6; k++) begin
            logic [31:0] p;
            p = (k == 0) ? 32'h0 : (k == 1) ? 32'hFFFF_FFFF : (k == 2) ? 32'h5555_AAAA :
                (k == 3) ? 32'h0001_2345 : (k == 4) ? 32'hFFF0_0000 : 32'h000F_0F0F;
            wr(5'h00, p); exp_dir = p & MASK;
            rd(5'h00, v); check("R4 dir readback", v, exp_dir);
            check("R4 pad_oe", pad_oe, ~exp_dir & MASK);
        end

        // R8 read-only and unmapped offsets
        wr(5'h04, 32'hFFFF_FFFF);
        rd(5'h04, v); check("R8 out word ro", v, exp_latch);
        wr(5'h10, 32'hFFFF_FFFF);
        rd(5'h04, v); check("R8 in word ro", v, exp_latch);
        for (int a = 5; a < 8; a++) begin
            wr(5'(a * 4), 32'h0);
            rd(5'(a * 4), v); check("R8 unmapped read", v, 32'h0);
        end
        rd(5'h04, v); check("R8 unmapped write", v, exp_latch);
        rd(5'h00, v); check("R8 unmapped dir", v, exp_dir);

        // R9 writes without select
        wr(5'h08, 32'hFFFF_FFFF, 1'b0);
        wr(5'h00, 32'h0, 1'b0);
        rd(5'h04, v); check("R9 latch held", v, exp_latch);
        rd(5'h00, v); check("R9 dir held", v, exp_dir);

        // R5 latency and R6 pad level with outputs driven
        wr(5'h00, 32'h0); exp_dir = 0;
        for (int k = 0; k < 5; k++) begin
            logic [31:0] p, prev;
            p = (k == 0) ? 32'hDEAD_BEEF : (k == 1) ? 32'h0 : (k == 2) ? ~exp_latch :
                (k == 3) ? 32'h000A_5A5A : 32'hFFFF_FFFF;
            @(negedge clk);
            bus_addr = 5'h10;
            prev = pad_in;
            pad_in = p;
            @(posedge clk); #2;
            check("R5 first edge old", bus_rdata, prev & MASK);
            @(posedge clk); #2;
            check("R5 second edge new", bus_rdata, p & MASK);
            check("R6 pad not latch", bus_rdata, p & MASK);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule